// File: doc/BRIEF.md
# Circuit Emulation Playout Buffer

This block sits between cell reassembly and a constant-rate line transmitter in a circuit emulation path. Bytes written by reassembly arrive in irregular bursts, while the line side pulls one byte per read at a steady rate. The buffer absorbs that delay variation, so the line keeps running while the network is jittery.

Two configured fill marks govern playout. After reset, and after any starvation, the buffer holds back data and plays the idle byte 0xFF until the low mark has built up. Past the high mark, it discards arriving bytes until the level has drained back to the low mark. One counter tallies the idle bytes sent out and another tallies the bytes thrown away. Both stop at their maximum value. Typical high marks are the channel's buffer size: up to 16224 bytes for unstructured channels, or a multiple of the timeslot count for structured ones. Storage is a single-clock dual-port RAM of `DEPTH` bytes.

Top module: `cem_playout_buf`

## Requirements
- R1: While and after reset, `underflow` is 1, `overflow` is 0, `level` is 0 and both counters are 0.
- R2: While `underflow` is 1, a read removes no stored byte. `underflow` falls at the edge after a cycle in which `level >= cfg_lo` was presented.
- R3: Every read that does not return stored data returns 0xFF on `rd_data` one cycle later, with `rd_valid` high, and increments `ins_cnt` at the same edge.
- R4: When `underflow` is 0, a read with `level` equal to 0 is a fill read (R3) and sets `underflow` at that edge.
- R5: When `underflow` is 0 and `level` is above 0, a read returns the oldest stored byte on `rd_data` in the following cycle. Bytes leave in the order they were accepted.
- R6: When `overflow` is 0, a write with `level >= cfg_hi` is discarded, sets `overflow` and increments `drop_cnt`. A write with `level < cfg_hi` is stored.
- R7: While `overflow` is 1, every write is discarded and counted. `overflow` falls at the edge after a cycle in which `level <= cfg_lo` was presented.
- R8: `ins_cnt` and `drop_cnt` saturate at all-ones and never wrap.
- R9: `level` rises by 1 per stored byte and falls by 1 per popped byte. A simultaneous store and pop leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_lo | input | LVL_W | Low mark, at least 1 |
| cfg_hi | input | LVL_W | High mark, above cfg_lo and at most DEPTH |
| wr_en | input | 1 | Byte offered from reassembly |
| wr_data | input | 8 | Offered byte |
| rd_en | input | 1 | Line side requests one byte |
| rd_data | output | 8 | Byte played out, valid the cycle after rd_en |
| rd_valid | output | 1 | rd_data carries the answer to last cycle's rd_en |
| underflow | output | 1 | Hold/starved state: playing 0xFF |
| overflow | output | 1 | Discard state |
| level | output | LVL_W | Bytes currently stored |
| ins_cnt | output | CNT_W | Saturating count of 0xFF bytes played |
| drop_cnt | output | CNT_W | Saturating count of discarded bytes |

## Verification
All results are registered, so each one is due at the first clock edge after its stimulus. The state flags, the level and both counters show the effect of a cycle's read and write at that edge. The byte answering a read appears on `rd_data` in the cycle after `rd_en`. The bench drives inputs on the falling edge and compares everything on the next falling edge. Each model step is therefore set against the outputs exactly one rising edge later. The threshold decisions are taken on the level presented in the same cycle as the request, and the bench model uses that same pre-edge level.

// File: rtl/cem_playout_pkg.sv
// Package: shared constants and helpers for the playout buffer.
// Assumes: byte-wide data path.
package cem_playout_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/cem_pb_ram.sv
// Module: simple dual-port RAM, one clock, registered read.
// Assumes: the caller never reads and writes the same address in one cycle.
module cem_pb_ram #(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store an accepted byte.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Fetch the head byte on a pop.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/cem_pb_satcnt.sv
// Module: saturating event counter.
// Assumes: one increment per cycle at most.
module cem_pb_satcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count up and stick at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (inc && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cem_pb_ctrl.sv
// Module: pointer, level and threshold state machine for the playout buffer.
// Assumes: 1 <= lo < hi <= DEPTH; decisions use the level before the edge.
module cem_pb_ctrl #(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8,
    parameter int LVL_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  cfg_lo,
    input  logic [LVL_W-1:0]  cfg_hi,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              push,
    output logic              pop,
    output logic              fill_rd,
    output logic              drop,
    output logic [ADDR_W-1:0] wptr,
    output logic [ADDR_W-1:0] rptr,
    output logic [LVL_W-1:0]  level,
    output logic              starved,
    output logic              flooded
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    logic empty;
    logic at_hi;

    // Decide what happens to this cycle's read and write.
    always_comb begin
        empty   = (level == '0);
        at_hi   = (level >= cfg_hi);
        pop     = rd_en && !starved && !empty;
        fill_rd = rd_en && !pop;
        push    = wr_en && !flooded && !at_hi;
        drop    = wr_en && !push;
    end

    // Advance the write pointer, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)    wptr <= '0;
        else if (push) wptr <= (wptr == LAST_ADDR) ? '0 : wptr + 1'b1;
    end

    // Advance the read pointer, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)   rptr <= '0;
        else if (pop) rptr <= (rptr == LAST_ADDR) ? '0 : rptr + 1'b1;
    end

    // Track stored byte count.
    always_ff @(posedge clk) begin
        if (!rst_n)            level <= '0;
        else if (push && !pop) level <= level + 1'b1;
        else if (pop && !push) level <= level - 1'b1;
    end

    // Hold/starved state: entered on an empty read, left once the low mark is met.
    always_ff @(posedge clk) begin
        if (!rst_n)       starved <= 1'b1;
        else if (starved) starved <= (level < cfg_lo);
        else              starved <= rd_en && empty;
    end

    // Discard state: entered on a write at the high mark, left at the low mark.
    always_ff @(posedge clk) begin
        if (!rst_n)       flooded <= 1'b0;
        else if (flooded) flooded <= (level > cfg_lo);
        else              flooded <= wr_en && at_hi;
    end
endmodule

// File: rtl/cem_playout_buf.sv
// Module: circuit emulation playout buffer top.
// Assumes: single clock; cfg_lo/cfg_hi quasi-static with 1 <= lo < hi <= DEPTH.
module cem_playout_buf
    import cem_playout_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int CNT_W = 16,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  cfg_lo,
    input  logic [LVL_W-1:0]  cfg_hi,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              underflow,
    output logic              overflow,
    output logic [LVL_W-1:0]  level,
    output logic [CNT_W-1:0]  ins_cnt,
    output logic [CNT_W-1:0]  drop_cnt
);
    logic              push, pop, fill_rd, drop;
    logic [ADDR_W-1:0] wptr, rptr;
    logic [7:0]        ram_q;
    logic              fill_q;

    cem_pb_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .wr_en(wr_en), .rd_en(rd_en), .push(push), .pop(pop),
        .fill_rd(fill_rd), .drop(drop), .wptr(wptr), .rptr(rptr),
        .level(level), .starved(underflow), .flooded(overflow)
    );

    cem_pb_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_ram (
        .clk(clk), .we(push), .waddr(wptr), .wdata(wr_data),
        .re(pop), .raddr(rptr), .rdata(ram_q)
    );

    cem_pb_satcnt #(.CNT_W(CNT_W)) u_ins_cnt (
        .clk(clk), .rst_n(rst_n), .inc(fill_rd), .cnt(ins_cnt)
    );

    cem_pb_satcnt #(.CNT_W(CNT_W)) u_drop_cnt (
        .clk(clk), .rst_n(rst_n), .inc(drop), .cnt(drop_cnt)
    );

    // Remember whether last cycle's read was answered from storage or fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            fill_q   <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            fill_q   <= fill_rd;
        end
    end

    // Select the played byte.
    always_comb rd_data = fill_q ? IDLE_BYTE : ram_q;
endmodule

// File: rtl/cem_playout_buf_chk.sv
// Module: property checker for the playout buffer, bound to the top.
// Assumes: observes ports only.
module cem_playout_buf_chk #(
    parameter int LVL_W = 9,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] cfg_lo,
    input logic [LVL_W-1:0] cfg_hi,
    input logic             wr_en,
    input logic             rd_en,
    input logic [7:0]       rd_data,
    input logic             rd_valid,
    input logic             underflow,
    input logic             overflow,
    input logic [LVL_W-1:0] level,
    input logic [CNT_W-1:0] ins_cnt,
    input logic [CNT_W-1:0] drop_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> underflow && !overflow && level == '0 && ins_cnt == '0 && drop_cnt == '0); // R1

    AST_HOLD_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        underflow && rd_en && !wr_en |=> level == $past(level)); // R2

    AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        underflow && level >= cfg_lo |=> !underflow); // R2

    AST_FILL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && underflow |=> rd_valid && rd_data == 8'hFF); // R3

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !underflow && level == '0 |=> underflow && rd_data == 8'hFF); // R4

    AST_OVF_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !overflow && level >= cfg_hi |=> overflow); // R6

    AST_OVF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && overflow && drop_cnt != CNT_MAX |=> drop_cnt == $past(drop_cnt) + 1'b1); // R7

    AST_OVF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && level <= cfg_lo |=> !overflow); // R7

    AST_INS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        ins_cnt == CNT_MAX |=> ins_cnt == CNT_MAX); // R8

    AST_DROP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        drop_cnt == CNT_MAX |=> drop_cnt == CNT_MAX); // R8

    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !rd_en && !overflow && level < cfg_hi |=> level == $past(level) + 1'b1); // R9
endmodule

bind cem_playout_buf cem_playout_buf_chk #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .underflow(underflow), .overflow(overflow), .level(level),
    .ins_cnt(ins_cnt), .drop_cnt(drop_cnt)
);

// File: tb/test_cem_playout_buf.sv
module test_cem_playout_buf;
    localparam int DEPTH = 32;
    localparam int CNT_W = 6;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int LO = 8;
    localparam int HI = 24;
    localparam int CMAX = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LVL_W-1:0] cfg_lo = LVL_W'(LO);
    logic [LVL_W-1:0] cfg_hi = LVL_W'(HI);
    logic             wr_en = 1'b0;
    logic [7:0]       wr_data = 8'h00;
    logic             rd_en = 1'b0;
    logic [7:0]       rd_data;
    logic             rd_valid;
    logic             underflow, overflow;
    logic [LVL_W-1:0] level;
    logic [CNT_W-1:0] ins_cnt, drop_cnt;

    int errors = 0;
    int checks = 0;

    // Reference model state
    byte unsigned m_q[$];
    bit  m_uf, m_of;
    int  m_ins, m_drop;
    bit  e_valid;
    bit  e_fill;
    byte unsigned e_data;

    cem_playout_buf #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_cem_playout_buf (
        .clk(clk), .rst_n(rst_n), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .underflow(underflow),
        .overflow(overflow), .level(level), .ins_cnt(ins_cnt), .drop_cnt(drop_cnt)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sat_inc(input int v);
        return (v < CMAX) ? v + 1 : v;
    endfunction

    // Model one cycle from the requirements, using the pre-edge level.
    task automatic model_step(input bit we, input bit re, input byte unsigned wd);
        int  sz = m_q.size();
        bit  pop  = re && !m_uf && sz > 0;
        bit  push = we && !m_of && sz < HI;
        bit  nuf  = m_uf ? (sz < LO) : (re && sz == 0);
        bit  nof  = m_of ? (sz > LO) : (we && sz >= HI);
        e_valid = re;
        e_fill  = re && !pop;
        if (e_fill) m_ins = sat_inc(m_ins);
        if (we && !push) m_drop = sat_inc(m_drop);
        if (pop) e_data = m_q.pop_front();
        if (push) m_q.push_back(wd);
        m_uf = nuf;
        m_of = nof;
    endtask

    task automatic compare_all();
        check("R5 rd_valid", int'(rd_valid), int'(e_valid));
        if (e_valid) begin
            if (e_fill) check("R3 fill byte", int'(rd_data), 255);
            else        check("R5 data order", int'(rd_data), int'(e_data));
        end
        check("R4/R2 underflow", int'(underflow), int'(m_uf));
        check("R6/R7 overflow", int'(overflow), int'(m_of));
        check("R9 level", int'(level), m_q.size());
        check("R3 ins_cnt", int'(ins_cnt), m_ins);
        check("R6 drop_cnt", int'(drop_cnt), m_drop);
    endtask

    task automatic cycle(input bit we, input bit re, input byte unsigned wd);
        wr_en = we; rd_en = re; wr_data = wd;
        model_step(we, re, wd);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed = 1234;
        void'($urandom(seed));
        m_uf = 1; m_of = 0; m_ins = 0; m_drop = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 underflow", int'(underflow), 1);
        check("R1 overflow", int'(overflow), 0);
        check("R1 level", int'(level), 0);
        check("R1 ins_cnt", int'(ins_cnt), 0);
        check("R1 drop_cnt", int'(drop_cnt), 0);
        rst_n = 1'b1;

        // R2: reads during hold give 0xFF and leave stored data in place
        for (int i = 0; i < LO; i++) cycle(1, 1, byte'(8'h10 + i));
        cycle(0, 1, 8'h00);          // level==LO seen here, still hold this cycle
        check("R2 hold exit", int'(underflow), 0);
        // R5: stored bytes come out in order
        for (int i = 0; i < 4; i++) cycle(0, 1, 8'h00);
        // R9: simultaneous read and write
        for (int i = 0; i < 6; i++) cycle(1, 1, byte'(8'hA0 + i));
        // R4: drain to empty, then one more read starves
        while (m_q.size() > 0) cycle(0, 1, 8'h00);
        cycle(0, 1, 8'h00);
        check("R4 underflow set", int'(underflow), 1);

        // R6/R7: fill past high mark, then drain to low mark
        for (int i = 0; i < HI + 4; i++) cycle(1, 0, byte'(i));
        check("R6 overflow set", int'(overflow), 1);
        while (m_of) cycle(1, 1, 8'h55);
        check("R7 overflow clear", int'(overflow), 0);

        // Constrained random phases with varying read/write mix
        for (int ph = 0; ph < 6; ph++) begin
            int wp = (ph % 3 == 0) ? 80 : (ph % 3 == 1) ? 30 : 55;
            for (int n = 0; n < 600; n++) begin
                bit we = ($urandom % 100) < wp;
                bit re = ($urandom % 100) < 55;
                cycle(we, re, byte'($urandom));
            end
        end

        // R8: force both counters to saturate
        for (int i = 0; i < CMAX + 8; i++) cycle(1, 0, 8'h33);
        check("R8 drop_cnt sat", int'(drop_cnt), CMAX);
        while (m_q.size() > 0) cycle(0, 1, 8'h00);
        for (int i = 0; i < CMAX + 8; i++) cycle(0, 1, 8'h00);
        check("R8 ins_cnt sat", int'(ins_cnt), CMAX);

        wr_en = 0; rd_en = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule